// File: doc/BRIEF.md
# Two-Thread Fetch Priority Arbiter

This block decides, on every clock cycle, which of two hardware threads sharing one instruction fetch front end receives the fetch slot. The leading thread runs ahead speculatively. The trailing thread re-executes the leading thread's retired work, which it reads from a result queue between the two threads. The arbiter looks at a policy select, a fetch-ready flag from each thread, the current fill count of that result queue and each thread's in-flight instruction count. It returns a registered one-hot grant and a valid flag.

Four policies are available. The first alternates between the threads. The second favours the thread with fewer instructions in flight. The third always favours the trailing thread. The fourth keys priority to how full the result queue is, with the switchover at half of its capacity. In every policy, a thread that is not ready gives up its slot to the other thread if that thread is ready. All policies share one history bit that records which thread was granted last.

Top module: `fetch_prio_arb`

## Requirements
- R1: `grant_o` has at most one bit set, where bit 0 is the leading thread and bit 1 is the trailing thread. `grant_vld_o` is high exactly when one bit is set.
- R2: In mode 0 (alternating), when both threads are ready, the grant goes to the thread that was not granted most recently. Before any grant has been issued since reset, the leading thread is taken as the one to serve first.
- R3: The thread granted most recently changes only on cycles that issue a grant. Cycles with no grant leave the alternation where it was.
- R4: In mode 1 (in-flight count), the ready thread with the strictly smaller in-flight count has priority.
- R5: In mode 1, when the two counts are equal, priority goes to the thread not granted most recently. That is the leading thread if no grant has been issued since reset.
- R6: In mode 2 (trailing first), the trailing thread is granted whenever it is ready.
- R7: In mode 3 (queue fill), the leading thread has priority while the queue occupancy is below half of the queue capacity. That half-point is 256 for the default capacity of 512.
- R8: In mode 3, the trailing thread has priority when the occupancy is at or above the half-point, up to and including a full queue.
- R9: When the priority thread is not ready and the other thread is, the other thread is granted.
- R10: When neither thread is ready, `grant_vld_o` is low and `grant_o` is 0.
- R11: The grant appears one clock after the inputs it was computed from. A change of mode therefore governs the very next grant.
- R12: While `rst_n` is low and on the first cycle after it, `grant_o` is 0 and `grant_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Policy: 0 alternating, 1 in-flight count, 2 trailing first, 3 queue fill |
| lead_rdy_i | input | 1 | Leading thread can fetch this cycle |
| trail_rdy_i | input | 1 | Trailing thread can fetch this cycle |
| q_occ_i | input | OCC_W (10) | Current result-queue occupancy |
| lead_inflight_i | input | CNT_W (8) | Leading thread in-flight instruction count |
| trail_inflight_i | input | CNT_W (8) | Trailing thread in-flight instruction count |
| grant_o | output | 2 | One-hot grant, bit 0 leading, bit 1 trailing |
| grant_vld_o | output | 1 | A grant is issued this cycle |

## Verification
The bench tests the queue-fill policy at occupancies 255, 256 and 512. A comparison that is off by one would move the switchover to the wrong side of the half-point. It places idle cycles in the middle of an alternating run. A design that updates its history on idle cycles would then grant the same thread twice in a row. It also applies equal in-flight counts twice in a row: a fixed tie-break would keep choosing one thread instead of alternating. Finally, it changes the mode between two back-to-back grants, which exposes any extra pipeline stage on the mode input. Around these directed cases, a long random run is compared against a model of the requirements kept in the bench.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

  typedef enum logic [1:0] {
    FPA_ROUND       = 2'd0,
    FPA_COUNT       = 2'd1,
    FPA_TRAIL_FIRST = 2'd2,
    FPA_QUEUE_FILL  = 2'd3
  } fpa_mode_e;

  localparam logic THR_LEAD  = 1'b0;
  localparam logic THR_TRAIL = 1'b1;

  // Queue-fill rule: trailing side is favoured at or above the half-point.
  function automatic logic fill_favors_trail(input logic [31:0] occ,
                                             input logic [31:0] half);
    return (occ >= half);
  endfunction

  // In-flight rule: fewer instructions wins; equal counts go to the thread
  // that did not receive the most recent grant.
  function automatic logic count_pick(input logic [31:0] lead_cnt,
                                      input logic [31:0] trail_cnt,
                                      input logic        last_thr);
    if (lead_cnt < trail_cnt) return THR_LEAD;
    if (trail_cnt < lead_cnt) return THR_TRAIL;
    return ~last_thr;
  endfunction

endpackage

// File: rtl/fpa_policy.sv
module fpa_policy
  import fpa_pkg::*;
#(
  parameter int OCC_W = 10,
  parameter int CNT_W = 8,
  parameter int HALF  = 256
) (
  input  fpa_mode_e        mode,
  input  logic [OCC_W-1:0] occ,
  input  logic [CNT_W-1:0] lead_cnt,
  input  logic [CNT_W-1:0] trail_cnt,
  input  logic             last_thr,
  output logic             prio_thr
);

  logic fill_pick;
  logic cnt_pick;

  assign fill_pick = fill_favors_trail(32'(occ), 32'(HALF)) ? THR_TRAIL : THR_LEAD;
  assign cnt_pick  = count_pick(32'(lead_cnt), 32'(trail_cnt), last_thr);

  always_comb begin
    unique case (mode)
      FPA_ROUND:       prio_thr = ~last_thr;
      FPA_COUNT:       prio_thr = cnt_pick;
      FPA_TRAIL_FIRST: prio_thr = THR_TRAIL;
      FPA_QUEUE_FILL:  prio_thr = fill_pick;
      default:         prio_thr = THR_LEAD;
    endcase
  end

endmodule

// File: rtl/fpa_select.sv
module fpa_select #(
  parameter int N_THR = 2
) (
  input  logic             prio_thr,
  input  logic [N_THR-1:0] rdy,
  output logic [N_THR-1:0] grant_nxt,
  output logic             any_grant
);

  logic prio_ready;
  assign prio_ready = rdy[prio_thr];

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    logic is_prio;
    assign is_prio      = (prio_thr == 1'(t));
    assign grant_nxt[t] = rdy[t] && (is_prio || !prio_ready);
  end

  assign any_grant = |grant_nxt;

endmodule

// File: rtl/fpa_hist.sv
module fpa_hist #(
  parameter int N_THR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_THR-1:0] grant_nxt,
  input  logic             any_grant,
  output logic [N_THR-1:0] grant_q,
  output logic             vld_q,
  output logic             last_thr
);

  logic granted_thr;
  assign granted_thr = grant_nxt[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q  <= '0;
      vld_q    <= 1'b0;
      last_thr <= 1'b1;
    end else begin
      grant_q <= grant_nxt;
      vld_q   <= any_grant;
      if (any_grant) last_thr <= granted_thr;
    end
  end

endmodule

// File: rtl/fetch_prio_arb.sv
module fetch_prio_arb
  import fpa_pkg::*;
#(
  parameter int Q_DEPTH = 512,
  parameter int CNT_W   = 8,
  localparam int OCC_W  = $clog2(Q_DEPTH + 1),
  localparam int HALF   = Q_DEPTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             lead_rdy_i,
  input  logic             trail_rdy_i,
  input  logic [OCC_W-1:0] q_occ_i,
  input  logic [CNT_W-1:0] lead_inflight_i,
  input  logic [CNT_W-1:0] trail_inflight_i,
  output logic [1:0]       grant_o,
  output logic             grant_vld_o
);

  localparam int N_THR = 2;

  fpa_mode_e        mode;
  logic             prio_thr;
  logic [N_THR-1:0] rdy;
  logic [N_THR-1:0] grant_nxt;
  logic             any_grant;
  logic             last_thr;

  assign mode = fpa_mode_e'(mode_i);
  assign rdy  = {trail_rdy_i, lead_rdy_i};

  fpa_policy #(.OCC_W(OCC_W), .CNT_W(CNT_W), .HALF(HALF)) u_policy (
    .mode      (mode),
    .occ       (q_occ_i),
    .lead_cnt  (lead_inflight_i),
    .trail_cnt (trail_inflight_i),
    .last_thr  (last_thr),
    .prio_thr  (prio_thr)
  );

  fpa_select #(.N_THR(N_THR)) u_select (
    .prio_thr  (prio_thr),
    .rdy       (rdy),
    .grant_nxt (grant_nxt),
    .any_grant (any_grant)
  );

  fpa_hist #(.N_THR(N_THR)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant_nxt (grant_nxt),
    .any_grant (any_grant),
    .grant_q   (grant_o),
    .vld_q     (grant_vld_o),
    .last_thr  (last_thr)
  );

endmodule

// File: rtl/fpa_checker.sv
module fpa_checker #(
  parameter int OCC_W = 10,
  parameter int CNT_W = 8,
  parameter int HALF  = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             lead_rdy_i,
  input logic             trail_rdy_i,
  input logic [OCC_W-1:0] q_occ_i,
  input logic [CNT_W-1:0] lead_inflight_i,
  input logic [CNT_W-1:0] trail_inflight_i,
  input logic [1:0]       grant_o,
  input logic             grant_vld_o,
  input logic             prio_thr
);

  logic both_rdy;
  assign both_rdy = lead_rdy_i && trail_rdy_i;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R1
  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld_o == (grant_o != 2'b00)); // R1
  AST_ROUND_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_i == 2'd0) && $past(both_rdy) && $past(grant_vld_o))
      |-> (grant_o == ~$past(grant_o))); // R2
  AST_TRAIL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_i == 2'd2) && $past(trail_rdy_i))
      |-> (grant_o == 2'b10)); // R6
  AST_FILL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_i == 2'd3) && $past(32'(q_occ_i) < 32'(HALF))
     && $past(lead_rdy_i)) |-> (grant_o == 2'b01)); // R7
  AST_FILL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_i == 2'd3) && $past(32'(q_occ_i) >= 32'(HALF))
     && $past(trail_rdy_i)) |-> (grant_o == 2'b10)); // R8
  AST_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(lead_rdy_i ^ trail_rdy_i))
      |-> (grant_vld_o && grant_o == {$past(trail_rdy_i), $past(lead_rdy_i)})); // R9
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!lead_rdy_i && !trail_rdy_i)) |-> !grant_vld_o); // R10
  AST_PRIO_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(both_rdy)) |-> grant_o[$past(prio_thr)]); // R11

endmodule

bind fetch_prio_arb fpa_checker #(.OCC_W(OCC_W), .CNT_W(CNT_W), .HALF(HALF)) u_fpa_checker (
  .clk              (clk),
  .rst_n            (rst_n),
  .mode_i           (mode_i),
  .lead_rdy_i       (lead_rdy_i),
  .trail_rdy_i      (trail_rdy_i),
  .q_occ_i          (q_occ_i),
  .lead_inflight_i  (lead_inflight_i),
  .trail_inflight_i (trail_inflight_i),
  .grant_o          (grant_o),
  .grant_vld_o      (grant_vld_o),
  .prio_thr         (prio_thr)
);

// File: tb/fetch_prio_arb_bench.sv
module fetch_prio_arb_bench;

  localparam int CLK_PERIOD = 10;
  localparam int Q_DEPTH    = 512;
  localparam int CNT_W      = 8;
  localparam int OCC_W      = $clog2(Q_DEPTH + 1);
  localparam int HALF_PT    = Q_DEPTH / 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mode_i = 2'd0;
  logic             lead_rdy_i = 1'b0;
  logic             trail_rdy_i = 1'b0;
  logic [OCC_W-1:0] q_occ_i = '0;
  logic [CNT_W-1:0] lead_inflight_i = '0;
  logic [CNT_W-1:0] trail_inflight_i = '0;
  logic [1:0]       grant_o;
  logic             grant_vld_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0] g;
    logic       v;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  // bench-side history: thread that won most recently (1 = trailing)
  bit model_last = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_prio_arb #(.Q_DEPTH(Q_DEPTH), .CNT_W(CNT_W)) u_fetch_prio_arb (
    .clk              (clk),
    .rst_n            (rst_n),
    .mode_i           (mode_i),
    .lead_rdy_i       (lead_rdy_i),
    .trail_rdy_i      (trail_rdy_i),
    .q_occ_i          (q_occ_i),
    .lead_inflight_i  (lead_inflight_i),
    .trail_inflight_i (trail_inflight_i),
    .grant_o          (grant_o),
    .grant_vld_o      (grant_vld_o)
  );

  task automatic check(input string tag, input logic [1:0] g, input logic v,
                       input logic [1:0] eg, input logic ev);
    checks++;
    if (g !== eg || v !== ev) begin
      errors++;
      $display("FAIL %s: grant=%b vld=%b expected grant=%b vld=%b", tag, g, v, eg, ev);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected grant.
  task automatic drive(input string tag, input int m, input bit lr, input bit tr,
                       input int occ, input int lc, input int tc);
    bit want_trail;
    exp_t e;
    @(negedge clk);
    mode_i           = 2'(m);
    lead_rdy_i       = lr;
    trail_rdy_i      = tr;
    q_occ_i          = OCC_W'(occ);
    lead_inflight_i  = CNT_W'(lc);
    trail_inflight_i = CNT_W'(tc);
    case (m)
      0:       want_trail = !model_last;
      1:       want_trail = (tc < lc) ? 1'b1 : (lc < tc) ? 1'b0 : !model_last;
      2:       want_trail = 1'b1;
      default: want_trail = (occ >= HALF_PT);
    endcase
    if (want_trail && !tr && lr) want_trail = 1'b0;
    if (!want_trail && !lr && tr) want_trail = 1'b1;
    if (!lr && !tr) begin
      e.g = 2'b00; e.v = 1'b0;
    end else begin
      e.g = want_trail ? 2'b10 : 2'b01; e.v = 1'b1;
      model_last = want_trail;
    end
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compares one result per clock, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, grant_o, grant_vld_o, e.g, e.v);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired (all requirements)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    lead_rdy_i = 1'b1;
    trail_rdy_i = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R12 in reset", grant_o, grant_vld_o, 2'b00, 1'b0);
    @(negedge clk);
    lead_rdy_i = 1'b0;
    trail_rdy_i = 1'b0;
    rst_n = 1'b1;
    @(posedge clk);
    #1 check("R12 after reset", grant_o, grant_vld_o, 2'b00, 1'b0);

    // R2 alternating with both ready, leading first after reset
    drive("R2 alt first lead", 0, 1, 1, 0, 0, 0);
    drive("R2 alt trail", 0, 1, 1, 0, 0, 0);
    drive("R2 alt lead", 0, 1, 1, 0, 0, 0);
    drive("R2 alt trail again", 0, 1, 1, 0, 0, 0);
    // R10 idle, R3 idle leaves history untouched
    drive("R10 none ready", 0, 0, 0, 0, 0, 0);
    drive("R10 none ready again", 0, 0, 0, 0, 0, 0);
    drive("R3 resume after idle", 0, 1, 1, 0, 0, 0);
    drive("R9 rr only trail", 0, 0, 1, 0, 0, 0);
    drive("R3 rr after fallback", 0, 1, 1, 0, 0, 0);

    // R4 / R5 count mode
    drive("R4 fewer trail", 1, 1, 1, 0, 5, 3);
    drive("R4 fewer lead", 1, 1, 1, 0, 2, 9);
    drive("R5 tie not last", 1, 1, 1, 0, 4, 4);
    drive("R5 tie flips", 1, 1, 1, 0, 4, 4);
    drive("R9 count fewer not ready", 1, 0, 1, 0, 1, 7);

    // R6 trailing first
    drive("R6 trail first", 2, 1, 1, 0, 0, 0);
    drive("R6 trail first again", 2, 1, 1, 0, 0, 0);
    drive("R9 trail not ready", 2, 1, 0, 0, 0, 0);
    drive("R10 trail-first idle", 2, 0, 0, 0, 0, 0);

    // R7 / R8 queue fill boundaries
    drive("R7 fill empty", 3, 1, 1, 0, 0, 0);
    drive("R7 fill just below half", 3, 1, 1, HALF_PT - 1, 0, 0);
    drive("R8 fill at half", 3, 1, 1, HALF_PT, 0, 0);
    drive("R8 fill nearly full", 3, 1, 1, Q_DEPTH - 1, 0, 0);
    drive("R8 fill full", 3, 1, 1, Q_DEPTH, 0, 0);
    drive("R9 fill lead not ready", 3, 0, 1, 100, 0, 0);

    // R11 mode change governs the next grant
    drive("R11 before switch", 2, 1, 1, 10, 0, 0);
    drive("R11 after switch", 3, 1, 1, 10, 0, 0);
    drive("R11 switch to trail-first", 2, 1, 1, 10, 0, 0);

    // R1 random run against the bench model
    for (int i = 0; i < 400; i++) begin
      drive("R1 random", int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), int'($urandom_range(0, Q_DEPTH)),
            int'($urandom_range(0, 15)), int'($urandom_range(0, 15)));
    end

    @(negedge clk);
    lead_rdy_i = 1'b0;
    trail_rdy_i = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule